// File: doc/BRIEF.md
# Durable Transaction Commit Sequencer

This controller runs the work that follows the end of a durable hardware transaction. While a transaction runs, the first-level cache may push dirty transactional lines down into the last-level cache. Each time it does, the sequencer records only the line address in a small overflow list. The data itself stays in the last-level cache. Once the log reports that the transaction has logically committed, the sequencer does two walks. It first steps through every first-level tag and writes back each line whose transactional-write bit is set. It then goes through the overflow list in order, probes the last-level cache for each address, and writes a line back only when the probe finds it. When every write-back has been accepted, the sequencer emits a log truncation record and goes idle.

On abort, the sequencer first issues a single-cycle flash clear of the first-level transactional status bits. It then walks the overflow list and sends an invalidate to the last-level cache for each address. An abort produces no write-backs and no truncation record. The core may go on running non-transactional code while this background work proceeds, but a request to begin a new transaction is only granted once the sequencer is idle. During a commit walk, another core may ask for a line that still awaits write-back. In that case the sequencer writes that line back first and only then acknowledges the release. The acknowledgement tells the requester to record a dependency on this transaction.

Top module: `txn_commit_seq`

## Requirements
- R1: In the idle state an asserted `ovf_push` appends `ovf_push_addr` to an overflow list of `OVF_DEPTH` entries (16 by default). A push made while `busy` is high is ignored and leaves the list unchanged.
- R2: A push in the idle state while the list already holds `OVF_DEPTH` entries is dropped. On the next cycle `cap_abort` is high for exactly one cycle.
- R3: A `log_commit` pulse in the idle state starts a walk of first-level indices 0 to `L1_LINES-1` in ascending order. Each index whose `l1_tw` is 1 gets a write-back of `l1_line_addr`. `l1_clean` pulses in the cycle that write-back is accepted.
- R4: After the first-level walk, each overflow address is sent, oldest first, as a probe (`llc_req_inv`=0) to the last-level cache. A write-back of that address follows only when `llc_rsp_hit` is 1.
- R5: Once `wb_valid` is high, it stays high with `wb_addr` unchanged until `wb_ready` is high at a clock edge.
- R6: After the last commit write-back is accepted, `trunc_valid` rises. It stays high until `trunc_ready` is high, and the block then returns to idle. Exactly one truncation record is emitted per commit.
- R7: `busy` is low only in the idle state. `tx_start_grant` equals `tx_start_req` while `busy` is low and is 0 while `busy` is high.
- R8: Suppose `snp_valid` is taken during a commit walk, and the address is either in the overflow list or reported by `snp_in_l1`. The block then writes back `snp_addr`. `snp_ack` rises with `snp_dep`=1 in the cycle after that write-back is accepted.
- R9: Any other `snp_valid` (idle, abort, or a line that is not pending) is acknowledged on the next cycle with `snp_dep`=0 and produces no write-back.
- R10: A `tx_abort` pulse in the idle state pulses `l1_flash_clr` for one cycle. It then sends one invalidate (`llc_req_inv`=1) per overflow address, oldest first, and empties the list. It makes no write-back and no truncation record.
- R11: When `tx_abort` and `log_commit` are high in the same idle cycle, the abort path is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_start_req | input | 1 | Core asks to begin a transaction |
| tx_start_grant | output | 1 | Begin allowed this cycle |
| busy | output | 1 | Background commit or abort work in progress |
| ovf_push | input | 1 | Dirty transactional line pushed into the last-level cache |
| ovf_push_addr | input | ADDR_W | Line address of the pushed line |
| cap_abort | output | 1 | Overflow list was full, transaction must abort |
| log_commit | input | 1 | Log reports logical commit |
| tx_abort | input | 1 | Transaction aborted |
| l1_idx | output | IDX_W | First-level tag index being inspected |
| l1_tw | input | 1 | Transactional-write bit of the line at `l1_idx` |
| l1_line_addr | input | ADDR_W | Line address of the line at `l1_idx` |
| l1_clean | output | 1 | Clear transactional and dirty state at `l1_idx` |
| l1_flash_clr | output | 1 | Clear all first-level transactional status bits |
| llc_req_valid | output | 1 | Last-level request, one cycle |
| llc_req_addr | output | ADDR_W | Last-level request address |
| llc_req_inv | output | 1 | 1 = invalidate, 0 = presence probe |
| llc_rsp_valid | input | 1 | Last-level response |
| llc_rsp_hit | input | 1 | Line was present |
| wb_valid | output | 1 | Write-back request to persistent memory |
| wb_addr | output | ADDR_W | Write-back line address |
| wb_ready | input | 1 | Write-back accepted |
| trunc_valid | output | 1 | Log truncation record request |
| trunc_ready | input | 1 | Truncation record accepted |
| snp_valid | input | 1 | Remote request for a line, held until `snp_ack` |
| snp_addr | input | ADDR_W | Remote request line address |
| snp_in_l1 | input | 1 | First level holds that line with the transactional-write bit set |
| snp_ack | output | 1 | Ownership may be released |
| snp_dep | output | 1 | Requester must record a dependency on this transaction |

## Verification
A commit is run with only first-level dirty lines, at scattered indices including the last one, while `wb_ready` toggles. This shows that index order is kept and that the write-back handshake holds under stalls. A second commit mixes first-level lines with overflow addresses, some present in the last-level cache and some absent, which separates the probe-driven write-backs from the unconditional ones. Abort is tried on a full list reached through a capacity overflow, on a list with a live last-level line, and in the same cycle as a commit pulse. Together these separate invalidation from write-back. Remote requests are sent for a pending overflow line, for an unrelated line, and while idle, which separates early release from a plain acknowledgement.

// File: rtl/txn_commit_seq.sv
module txn_commit_seq #(
  parameter int ADDR_W    = 32,
  parameter int L1_LINES  = 64,
  parameter int OVF_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_start_req,
  output logic              tx_start_grant,
  output logic              busy,
  input  logic              ovf_push,
  input  logic [ADDR_W-1:0] ovf_push_addr,
  output logic              cap_abort,
  input  logic              log_commit,
  input  logic              tx_abort,
  output logic [$clog2(L1_LINES)-1:0] l1_idx,
  input  logic              l1_tw,
  input  logic [ADDR_W-1:0] l1_line_addr,
  output logic              l1_clean,
  output logic              l1_flash_clr,
  output logic              llc_req_valid,
  output logic [ADDR_W-1:0] llc_req_addr,
  output logic              llc_req_inv,
  input  logic              llc_rsp_valid,
  input  logic              llc_rsp_hit,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  input  logic              wb_ready,
  output logic              trunc_valid,
  input  logic              trunc_ready,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              snp_in_l1,
  output logic              snp_ack,
  output logic              snp_dep
);
  localparam int IDX_W = $clog2(L1_LINES);
  localparam int PTR_W = (OVF_DEPTH > 1) ? $clog2(OVF_DEPTH) : 1;
  localparam int CNT_W = $clog2(OVF_DEPTH + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(L1_LINES - 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(OVF_DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(OVF_DEPTH);

  typedef enum logic [2:0] {
    S_IDLE, S_WALK_L1, S_WALK_OVF, S_TRUNCATE, S_ABORT_CLR, S_ABORT_OVF
  } state_t;

  state_t state;

  logic [ADDR_W-1:0] ovf_mem [OVF_DEPTH];
  logic [OVF_DEPTH-1:0] ovf_vld;
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] ovf_cnt;
  logic [IDX_W-1:0] idx;
  logic llc_wait, ovf_wb_pend;
  logic snp_wb, main_hold;
  logic [ADDR_W-1:0] snp_wb_addr;

  logic fifo_empty, fifo_full, push_ok, pop;
  logic commit_walk, ovf_match, snp_take, snp_pend;
  logic main_req, main_owns, snp_owns, main_go, l1_adv;
  logic [ADDR_W-1:0] head_addr;

  assign head_addr   = ovf_mem[rd_ptr];
  assign fifo_empty  = (ovf_cnt == '0);
  assign fifo_full   = (ovf_cnt == FULL_CNT);
  assign push_ok     = (state == S_IDLE) && ovf_push && !fifo_full;
  assign busy        = (state != S_IDLE);
  assign tx_start_grant = tx_start_req && !busy;
  assign commit_walk = (state == S_WALK_L1) || (state == S_WALK_OVF);

  always_comb begin
    ovf_match = 1'b0;
    for (int i = 0; i < OVF_DEPTH; i++)
      if (ovf_vld[i] && ovf_mem[i] == snp_addr) ovf_match = 1'b1;
  end

  assign snp_take = snp_valid && !snp_wb && !snp_ack;
  assign snp_pend = commit_walk && (snp_in_l1 || ovf_match);

  assign main_req  = ((state == S_WALK_L1) && l1_tw) ||
                     ((state == S_WALK_OVF) && ovf_wb_pend);
  assign main_owns = main_req && (!snp_wb || main_hold);
  assign snp_owns  = snp_wb && !main_hold;
  assign main_go   = main_owns && wb_ready;

  assign wb_valid = main_owns || snp_owns;
  assign wb_addr  = snp_owns ? snp_wb_addr :
                    (state == S_WALK_L1) ? l1_line_addr : head_addr;

  assign l1_idx       = idx;
  assign l1_adv       = (state == S_WALK_L1) && (!l1_tw || main_go);
  assign l1_clean     = (state == S_WALK_L1) && main_go;
  assign l1_flash_clr = (state == S_ABORT_CLR);

  assign llc_req_valid = ((state == S_WALK_OVF) || (state == S_ABORT_OVF)) &&
                         !fifo_empty && !llc_wait && !ovf_wb_pend;
  assign llc_req_addr  = head_addr;
  assign llc_req_inv   = (state == S_ABORT_OVF);
  assign trunc_valid   = (state == S_TRUNCATE);

  assign pop = ((state == S_WALK_OVF) && main_go) ||
               (llc_wait && llc_rsp_valid && !((state == S_WALK_OVF) && llc_rsp_hit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      ovf_cnt <= '0;
      ovf_vld <= '0;
      cap_abort <= 1'b0;
    end else begin
      cap_abort <= (state == S_IDLE) && ovf_push && fifo_full;
      if (push_ok) begin
        ovf_mem[wr_ptr] <= ovf_push_addr;
        ovf_vld[wr_ptr] <= 1'b1;
        wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      end
      if (pop) begin
        ovf_vld[rd_ptr] <= 1'b0;
        rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      end
      if (push_ok && !pop) ovf_cnt <= ovf_cnt + 1'b1;
      else if (pop && !push_ok) ovf_cnt <= ovf_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx <= '0;
      llc_wait <= 1'b0;
      ovf_wb_pend <= 1'b0;
      main_hold <= 1'b0;
    end else begin
      main_hold <= main_owns && !wb_ready;
      if (llc_req_valid) llc_wait <= 1'b1;
      if (llc_wait && llc_rsp_valid) begin
        llc_wait <= 1'b0;
        if ((state == S_WALK_OVF) && llc_rsp_hit) ovf_wb_pend <= 1'b1;
      end
      if ((state == S_WALK_OVF) && main_go) ovf_wb_pend <= 1'b0;
      case (state)
        S_IDLE: begin
          idx <= '0;
          if (tx_abort) state <= S_ABORT_CLR;
          else if (log_commit) state <= S_WALK_L1;
        end
        S_WALK_L1: if (l1_adv) begin
          idx <= idx + 1'b1;
          if (idx == LAST_IDX) state <= S_WALK_OVF;
        end
        S_WALK_OVF:
          if (fifo_empty && !llc_wait && !ovf_wb_pend && !snp_wb) state <= S_TRUNCATE;
        S_TRUNCATE:  if (trunc_ready) state <= S_IDLE;
        S_ABORT_CLR: state <= S_ABORT_OVF;
        S_ABORT_OVF: if (fifo_empty && !llc_wait) state <= S_IDLE;
        default:     state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snp_wb <= 1'b0;
      snp_wb_addr <= '0;
      snp_ack <= 1'b0;
      snp_dep <= 1'b0;
    end else begin
      snp_ack <= 1'b0;
      snp_dep <= 1'b0;
      if (snp_take) begin
        if (snp_pend) begin
          snp_wb <= 1'b1;
          snp_wb_addr <= snp_addr;
        end else begin
          snp_ack <= 1'b1;
        end
      end
      if (snp_owns && wb_ready) begin
        snp_wb  <= 1'b0;
        snp_ack <= 1'b1;
        snp_dep <= 1'b1;
      end
    end
  end

  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_cnt <= FULL_CNT);
  a_r2_cap_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    cap_abort |-> $past(fifo_full));
  a_r5_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr));
  a_r6_trunc_drained: assert property (@(posedge clk) disable iff (!rst_n)
    trunc_valid |-> fifo_empty && !snp_wb && !wb_valid);
  a_r8_dep_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
    snp_ack && snp_dep |-> $past(wb_valid && wb_ready));
  a_r10_inv_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    llc_req_valid && llc_req_inv |-> !wb_valid);
  a_r10_clr_then_inv: assert property (@(posedge clk) disable iff (!rst_n)
    l1_flash_clr |=> !l1_flash_clr && !trunc_valid);
endmodule

// File: tb/txn_commit_seq_test.sv
module txn_commit_seq_test;
  localparam int AW = 32;
  localparam int NL = 64;
  localparam int ND = 16;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic tx_start_req = 0, ovf_push = 0, log_commit = 0, tx_abort = 0;
  logic [AW-1:0] ovf_push_addr = '0, snp_addr = '0;
  logic trunc_ready = 1, snp_valid = 0, ready_all = 1;
  logic tx_start_grant, busy, cap_abort, l1_tw, l1_clean, l1_flash_clr;
  logic [5:0] l1_idx;
  logic [AW-1:0] l1_line_addr, llc_req_addr, wb_addr;
  logic llc_req_valid, llc_req_inv, llc_rsp_valid = 0, llc_rsp_hit = 0;
  logic wb_valid, wb_ready, trunc_valid, snp_in_l1, snp_ack, snp_dep;
  logic cyc_bit = 0;

  logic tb_tw [NL];
  logic [AW-1:0] tb_ad [NL];
  logic [AW-1:0] llc_a [8];
  logic llc_v [8];

  int tests = 0, fails = 0;
  int wb_n = 0, probe_n = 0, inv_n = 0, trunc_n = 0, clean_n = 0, flash_n = 0, cap_n = 0;
  logic [AW-1:0] wb_log [256];

  txn_commit_seq #(.ADDR_W(AW), .L1_LINES(NL), .OVF_DEPTH(ND)) uut (
    .clk(clk), .rst_n(rst_n), .tx_start_req(tx_start_req), .tx_start_grant(tx_start_grant),
    .busy(busy), .ovf_push(ovf_push), .ovf_push_addr(ovf_push_addr), .cap_abort(cap_abort),
    .log_commit(log_commit), .tx_abort(tx_abort), .l1_idx(l1_idx), .l1_tw(l1_tw),
    .l1_line_addr(l1_line_addr), .l1_clean(l1_clean), .l1_flash_clr(l1_flash_clr),
    .llc_req_valid(llc_req_valid), .llc_req_addr(llc_req_addr), .llc_req_inv(llc_req_inv),
    .llc_rsp_valid(llc_rsp_valid), .llc_rsp_hit(llc_rsp_hit), .wb_valid(wb_valid),
    .wb_addr(wb_addr), .wb_ready(wb_ready), .trunc_valid(trunc_valid), .trunc_ready(trunc_ready),
    .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_in_l1(snp_in_l1), .snp_ack(snp_ack),
    .snp_dep(snp_dep));

  assign l1_tw = tb_tw[l1_idx];
  assign l1_line_addr = tb_ad[l1_idx];
  assign wb_ready = ready_all | cyc_bit;

  always_comb begin
    snp_in_l1 = 1'b0;
    for (int i = 0; i < NL; i++) if (tb_tw[i] && tb_ad[i] == snp_addr) snp_in_l1 = 1'b1;
  end

  always @(posedge clk) begin
    cyc_bit <= ~cyc_bit;
    if (rst_n) begin
      if (wb_valid && wb_ready) begin wb_log[wb_n[7:0]] <= wb_addr; wb_n <= wb_n + 1; end
      if (trunc_valid && trunc_ready) trunc_n <= trunc_n + 1;
      if (l1_clean) begin clean_n <= clean_n + 1; tb_tw[l1_idx] <= 1'b0; end
      if (l1_flash_clr) begin
        flash_n <= flash_n + 1;
        for (int i = 0; i < NL; i++) tb_tw[i] <= 1'b0;
      end
      if (cap_abort) cap_n <= cap_n + 1;
      llc_rsp_valid <= llc_req_valid;
      llc_rsp_hit <= 1'b0;
      if (llc_req_valid) begin
        if (llc_req_inv) inv_n <= inv_n + 1; else probe_n <= probe_n + 1;
        for (int i = 0; i < 8; i++) if (llc_v[i] && llc_a[i] == llc_req_addr) begin
          llc_rsp_hit <= 1'b1;
          if (llc_req_inv) llc_v[i] <= 1'b0;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!busy) return;
    end
  endtask

  task automatic pulse_commit();
    log_commit = 1; @(negedge clk); log_commit = 0;
  endtask

  task automatic pulse_abort();
    tx_abort = 1; @(negedge clk); tx_abort = 0;
  endtask

  task automatic push(input logic [AW-1:0] a);
    ovf_push = 1; ovf_push_addr = a; @(negedge clk); ovf_push = 0;
  endtask

  task automatic do_snoop(input logic [AW-1:0] a, output logic dep);
    snp_addr = a; snp_valid = 1; dep = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (snp_ack) begin dep = snp_dep; break; end
    end
    snp_valid = 0;
  endtask

  task automatic t_reset();
    check(!busy, "R7 busy after reset", busy, 0);
    check(!wb_valid && !trunc_valid && !llc_req_valid, "R6 outputs quiet after reset", wb_valid, 0);
    tx_start_req = 1; #1;
    check(tx_start_grant, "R7 grant when idle", tx_start_grant, 1);
    tx_start_req = 0;
  endtask

  task automatic t_commit_l1();
    int w0 = wb_n, t0 = trunc_n, c0 = clean_n;
    tb_tw[3] = 1; tb_tw[10] = 1; tb_tw[63] = 1;
    ready_all = 0;
    pulse_commit();
    wait_idle();
    ready_all = 1;
    check(wb_n - w0 == 3, "R3 write-back count", wb_n - w0, 3);
    check(wb_log[w0[7:0]] == tb_ad[3] && wb_log[w0[7:0]+1] == tb_ad[10] && wb_log[w0[7:0]+2] == tb_ad[63],
          "R3 index order", wb_log[w0[7:0]+2], tb_ad[63]);
    check(clean_n - c0 == 3 && !tb_tw[63], "R3 clean pulses", clean_n - c0, 3);
    check(trunc_n - t0 == 1, "R6 one truncation", trunc_n - t0, 1);
  endtask

  task automatic t_commit_ovf();
    int w0 = wb_n, p0 = probe_n, t0 = trunc_n;
    push(32'hA000); push(32'hA100); push(32'hA200);
    llc_a[0] = 32'hA000; llc_v[0] = 1; llc_a[1] = 32'hA200; llc_v[1] = 1;
    tb_tw[5] = 1;
    pulse_commit();
    tx_start_req = 1; #1;
    check(busy && !tx_start_grant, "R7 start stalled while busy", tx_start_grant, 0);
    tx_start_req = 0;
    wait_idle();
    tx_start_req = 1; #1;
    check(tx_start_grant, "R7 start granted after work", tx_start_grant, 1);
    tx_start_req = 0;
    check(probe_n - p0 == 3, "R4 probe per entry", probe_n - p0, 3);
    check(wb_n - w0 == 3, "R4 write-back only on hit", wb_n - w0, 3);
    check(wb_log[w0[7:0]] == tb_ad[5] && wb_log[w0[7:0]+1] == 32'hA000 && wb_log[w0[7:0]+2] == 32'hA200,
          "R4 order L1 then list", wb_log[w0[7:0]+1], 32'hA000);
    check(trunc_n - t0 == 1, "R6 truncation after list", trunc_n - t0, 1);
    llc_v[0] = 0; llc_v[1] = 0;
  endtask

  task automatic t_capacity_abort();
    int i0 = inv_n, w0 = wb_n, t0 = trunc_n, f0 = flash_n, k0 = cap_n, p0 = probe_n;
    for (int i = 0; i < ND; i++) push(32'hC000 + 32'(i) * 64);
    check(cap_n == k0, "R2 no abort below capacity", cap_n - k0, 0);
    push(32'hCF00);
    @(negedge clk);
    check(cap_n - k0 == 1, "R2 capacity abort pulse", cap_n - k0, 1);
    pulse_abort();
    wait_idle();
    check(inv_n - i0 == ND, "R10 invalidate per entry", inv_n - i0, ND);
    check(flash_n - f0 == 1, "R10 flash clear once", flash_n - f0, 1);
    check(wb_n == w0 && trunc_n == t0, "R10 no write-back or truncation", wb_n - w0, 0);
    pulse_commit();
    wait_idle();
    check(probe_n == p0, "R10 list emptied by abort", probe_n - p0, 0);
  endtask

  task automatic t_abort_l1();
    int w0 = wb_n;
    tb_tw[7] = 1;
    push(32'hD000); llc_a[2] = 32'hD000; llc_v[2] = 1;
    pulse_abort();
    wait_idle();
    check(wb_n == w0, "R10 abort writes nothing back", wb_n - w0, 0);
    check(!llc_v[2], "R10 last-level line invalidated", llc_v[2], 0);
    check(!tb_tw[7], "R10 first-level bits cleared", tb_tw[7], 0);
  endtask

  task automatic t_snoop();
    logic dep;
    int w0;
    push(32'hE000); llc_a[3] = 32'hE000; llc_v[3] = 1;
    tb_tw[20] = 1;
    pulse_commit();
    do_snoop(32'hE000, dep);
    check(dep == 1, "R8 dependency flagged", dep, 1);
    check(wb_n > 0 && wb_log[wb_n[7:0]-1] == 32'hE000, "R8 line written before release",
          wb_log[wb_n[7:0]-1], 32'hE000);
    w0 = wb_n;
    do_snoop(32'hEE00, dep);
    check(dep == 0 && wb_n == w0, "R9 unrelated line no dependency", dep, 0);
    wait_idle();
    check(trunc_n > 0, "R6 truncation after snoop", trunc_n, 1);
    w0 = wb_n;
    do_snoop(32'hE000, dep);
    check(dep == 0 && wb_n == w0, "R9 idle snoop no write-back", wb_n - w0, 0);
    llc_v[3] = 0;
  endtask

  task automatic t_push_busy();
    int p0;
    pulse_commit();
    push(32'hF000);
    wait_idle();
    p0 = probe_n;
    pulse_commit();
    wait_idle();
    check(probe_n == p0, "R1 push while busy ignored", probe_n - p0, 0);
  endtask

  task automatic t_abort_wins();
    int f0 = flash_n, t0 = trunc_n;
    log_commit = 1; tx_abort = 1; @(negedge clk); log_commit = 0; tx_abort = 0;
    wait_idle();
    check(flash_n - f0 == 1 && trunc_n == t0, "R11 abort over commit", trunc_n - t0, 0);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NL; i++) begin tb_tw[i] = 0; tb_ad[i] = 32'h1000 + 32'(i) * 64; end
    for (int i = 0; i < 8; i++) begin llc_v[i] = 0; llc_a[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_commit_l1();
    t_commit_ovf();
    t_capacity_abort();
    t_abort_l1();
    t_snoop();
    t_push_busy();
    t_abort_wins();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule